// File: doc/BRIEF.md
# Two-Level Page Table Walker (32-bit virtual addresses)

This block translates a 32-bit virtual address into a 34-bit physical address. It walks a two-level page table held in memory. A requester presents one translation at a time. The request carries:

- the virtual address;
- the access kind (fetch, load or store);
- the effective privilege mode;
- the root page number of the table;
- two control bits: one lets supervisor code touch user pages, one makes executable pages readable.

The walker reads page table entries one word at a time over a simple memory port. It applies every legality and permission rule to the leaf entry. If the accessed or dirty flag of the leaf must change, it writes the updated entry back. It then answers with either a physical address plus read, write and execute rights, or a fault.

Machine-mode requests and requests with translation switched off are answered at once with the address unchanged.

The control is a four-state machine:

- **IDLE** accepts a request. It goes to RESP for a pass-through request and to FETCH otherwise.
- **FETCH** holds a memory read until it is answered.
  - A pointer entry at the first level loops back into FETCH for the second level.
  - A leaf that passes every check goes to WRBACK when its flags change, and to RESP when they do not.
  - A read error, an invalid entry, an illegal leaf and a second-level pointer all go to RESP with a fault.
- **WRBACK** holds the write of the updated entry until it is answered, then goes to RESP. A write error turns the answer into a fault.
- **RESP** presents the answer for one cycle and returns to IDLE.

Top module: `vmw_walker`

## Requirements
- R1: A request with mode code 3 (machine) or with `req_xlat_off` set returns, with no memory access, `rsp_paddr` equal to the zero-extended virtual address, all three rights set and no fault.
- R2: An entry is a 32-bit word with this layout: valid bit 0, read bit 1, write bit 2, execute bit 3, user bit 4, bit 5 not used, accessed bit 6, dirty bit 7, page number bits 31:10. The first read address is root*4096 + va[31:22]*4. The second read address is the pointer's page number*4096 + va[21:12]*4.
- R3: An entry with the valid bit clear faults. A read answered with `mem_err` also faults.
- R4: A valid entry with read, write and execute all clear is a pointer. At the first level the walk continues; at the second level it faults.
- R5: A leaf with write set and read clear (write-only, or write plus execute) is reserved and faults.
- R6: Mode codes are 0 for user and 1 for supervisor; access codes are 0 fetch, 1 load, 2 store. A user page faults unless the mode is user, or the mode is supervisor with `req_sum` set and the access is not a fetch. A non-user page faults unless the mode is supervisor.
- R7: A first-level leaf whose page number bits 9:0 are nonzero faults.
- R8: A load needs read, or execute with `req_mxr` set. A store needs write. A fetch needs execute. Otherwise the request faults.
- R9: On success, the accessed bit is set, and for a store the dirty bit as well. The updated word is written back to the same address only when it differs from the word read. A write answered with `mem_err` faults.
- R10: The physical address is page number*4096 + va[11:0]. For a first-level leaf, va[21:12] replaces page number bits 9:0.
- R11: The rights returned are:
  - read = R or (X and MXR);
  - execute = X;
  - write = W and (store or dirty already set);
  - on a fault, all three rights and the address are zero.
- R12: `req_ready` is high only when idle. `rsp_valid` lasts one cycle. `mem_req` with its address and direction stays steady until `mem_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request taken |
| req_vaddr | input | 32 | Virtual address |
| req_acc | input | 2 | Access kind: 0 fetch, 1 load, 2 store |
| req_mode | input | 2 | Effective mode: 0 user, 1 supervisor, 3 machine |
| req_xlat_off | input | 1 | Translation switched off |
| req_root_ppn | input | 22 | Page number of the first-level table |
| req_sum | input | 1 | Supervisor may use user pages |
| req_mxr | input | 1 | Executable pages readable |
| mem_req | output | 1 | Memory access pending |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 34 | Entry address |
| mem_wdata | output | 32 | Updated entry |
| mem_valid | input | 1 | Access answered |
| mem_rdata | input | 32 | Entry read |
| mem_err | input | 1 | Access failed |
| rsp_valid | output | 1 | Answer present |
| rsp_fault | output | 1 | Translation failed |
| rsp_paddr | output | 34 | Physical address |
| rsp_r | output | 1 | Read right |
| rsp_w | output | 1 | Write right |
| rsp_x | output | 1 | Execute right |

## Verification
The hardest state to reach from the ports is a legal leaf that also needs its flags updated, where the write-back itself fails. Reaching it takes a valid pointer or an aligned superpage, matching ownership and access rights, a clear accessed or dirty bit, and an error placed on the write but not on the read. Random trials build fresh tables with pointer entries half the time, aligned superpage numbers half the time and mostly valid flags. They also aim read or write errors at chosen entry addresses. Directed cases cover each rule alone, including the failed write-back and a store whose flags are already set.

// File: rtl/vmw_pkg.sv
package vmw_pkg;
    localparam int VA_W  = 32;
    localparam int PA_W  = 34;
    localparam int PPN_W = 22;
    localparam int OFF_W = 12;
    localparam int IDX_W = 10;
    localparam int PTE_W = 32;
    localparam int ENTRY_LG = 2;

    localparam logic [1:0] ACC_FETCH = 2'd0;
    localparam logic [1:0] ACC_LOAD  = 2'd1;
    localparam logic [1:0] ACC_STORE = 2'd2;

    localparam logic [1:0] MODE_USER  = 2'd0;
    localparam logic [1:0] MODE_SUPER = 2'd1;
    localparam logic [1:0] MODE_MACH  = 2'd3;

    typedef struct packed {
        logic [PPN_W-1:0] ppn;
        logic [1:0]       rsw;
        logic             d;
        logic             a;
        logic             g;
        logic             u;
        logic             x;
        logic             w;
        logic             r;
        logic             v;
    } pte_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_WRBACK,
        ST_RESP
    } walk_state_e;
endpackage

// File: rtl/vmw_pte_addr.sv
module vmw_pte_addr
    import vmw_pkg::*;
(
    input  logic [PPN_W-1:0] base_ppn,
    input  logic [IDX_W-1:0] index,
    output logic [PA_W-1:0]  pte_addr
);
    localparam int IDX_BYTES_W = IDX_W + ENTRY_LG;

    logic [IDX_BYTES_W-1:0] byte_off;

    assign byte_off = {index, {ENTRY_LG{1'b0}}};
    assign pte_addr = {base_ppn, {OFF_W{1'b0}}} + PA_W'(byte_off);
endmodule

// File: rtl/vmw_pa_compose.sv
module vmw_pa_compose
    import vmw_pkg::*;
(
    input  logic [PPN_W-1:0]       ppn,
    input  logic [IDX_W+OFF_W-1:0] low_va,
    input  logic                   superpage,
    output logic [PA_W-1:0]        paddr
);
    always_comb begin
        if (superpage) begin
            paddr = {ppn[PPN_W-1:IDX_W], low_va};
        end else begin
            paddr = {ppn, low_va[OFF_W-1:0]};
        end
    end
endmodule

// File: rtl/vmw_leaf_check.sv
module vmw_leaf_check
    import vmw_pkg::*;
(
    input  pte_t       pte,
    input  logic [1:0] acc,
    input  logic [1:0] mode,
    input  logic       sum,
    input  logic       mxr,
    input  logic       top_level,
    output logic       is_ptr,
    output logic       leaf_ok,
    output logic       perm_r,
    output logic       perm_w,
    output logic       perm_x,
    output pte_t       pte_upd,
    output logic       wb_needed
);
    logic reserved;
    logic owner_bad;
    logic misaligned;
    logic access_bad;
    logic is_store;

    assign is_store = (acc == ACC_STORE);
    assign is_ptr   = pte.v && !pte.r && !pte.w && !pte.x;
    assign reserved = pte.w && !pte.r;

    always_comb begin
        if (pte.u) begin
            owner_bad = !((mode == MODE_USER) ||
                          ((mode == MODE_SUPER) && sum && (acc != ACC_FETCH)));
        end else begin
            owner_bad = (mode != MODE_SUPER);
        end
    end

    assign misaligned = top_level && (pte.ppn[IDX_W-1:0] != '0);

    always_comb begin
        unique case (acc)
            ACC_LOAD:  access_bad = !(pte.r || (pte.x && mxr));
            ACC_STORE: access_bad = !pte.w;
            ACC_FETCH: access_bad = !pte.x;
            default:   access_bad = 1'b1;
        endcase
    end

    assign leaf_ok = pte.v && !is_ptr && !reserved && !owner_bad &&
                     !misaligned && !access_bad;

    assign perm_r = pte.r || (pte.x && mxr);
    assign perm_x = pte.x;
    assign perm_w = pte.w && (is_store || pte.d);

    always_comb begin
        pte_upd   = pte;
        pte_upd.a = 1'b1;
        pte_upd.d = pte.d || is_store;
    end

    assign wb_needed = (pte_upd != pte);
endmodule

// File: rtl/vmw_walker.sv
module vmw_walker
    import vmw_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VA_W-1:0]  req_vaddr,
    input  logic [1:0]       req_acc,
    input  logic [1:0]       req_mode,
    input  logic             req_xlat_off,
    input  logic [PPN_W-1:0] req_root_ppn,
    input  logic             req_sum,
    input  logic             req_mxr,
    output logic             mem_req,
    output logic             mem_we,
    output logic [PA_W-1:0]  mem_addr,
    output logic [PTE_W-1:0] mem_wdata,
    input  logic             mem_valid,
    input  logic [PTE_W-1:0] mem_rdata,
    input  logic             mem_err,
    output logic             rsp_valid,
    output logic             rsp_fault,
    output logic [PA_W-1:0]  rsp_paddr,
    output logic             rsp_r,
    output logic             rsp_w,
    output logic             rsp_x
);
    localparam int VPN1_LO = OFF_W + IDX_W;

    walk_state_e      state_q, state_d;
    logic             lvl_top_q;
    logic [PPN_W-1:0] base_ppn_q;
    logic [VA_W-1:0]  vaddr_q;
    logic [1:0]       acc_q;
    logic [1:0]       mode_q;
    logic             sum_q;
    logic             mxr_q;
    pte_t             wb_pte_q;
    logic             fault_q;
    logic [PA_W-1:0]  paddr_q;
    logic             r_q, w_q, x_q;

    pte_t             pte_in;
    logic [IDX_W-1:0] cur_index;
    logic [PA_W-1:0]  pte_addr;
    logic [PA_W-1:0]  leaf_paddr;
    logic             is_ptr, leaf_ok, pr, pw, px, wb_needed;
    pte_t             pte_upd;
    logic             passthru;

    assign pte_in    = pte_t'(mem_rdata);
    assign cur_index = lvl_top_q ? vaddr_q[VA_W-1:VPN1_LO] : vaddr_q[VPN1_LO-1:OFF_W];
    assign passthru  = (req_mode == MODE_MACH) || req_xlat_off;

    vmw_pte_addr u_addr (
        .base_ppn (base_ppn_q),
        .index    (cur_index),
        .pte_addr (pte_addr)
    );

    vmw_leaf_check u_check (
        .pte       (pte_in),
        .acc       (acc_q),
        .mode      (mode_q),
        .sum       (sum_q),
        .mxr       (mxr_q),
        .top_level (lvl_top_q),
        .is_ptr    (is_ptr),
        .leaf_ok   (leaf_ok),
        .perm_r    (pr),
        .perm_w    (pw),
        .perm_x    (px),
        .pte_upd   (pte_upd),
        .wb_needed (wb_needed)
    );

    vmw_pa_compose u_pa (
        .ppn       (pte_in.ppn),
        .low_va    (vaddr_q[VPN1_LO-1:0]),
        .superpage (lvl_top_q),
        .paddr     (leaf_paddr)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    state_d = passthru ? ST_RESP : ST_FETCH;
                end
            end
            ST_FETCH: begin
                if (mem_valid) begin
                    if (mem_err) begin
                        state_d = ST_RESP;
                    end else if (is_ptr) begin
                        state_d = lvl_top_q ? ST_FETCH : ST_RESP;
                    end else if (!leaf_ok) begin
                        state_d = ST_RESP;
                    end else begin
                        state_d = wb_needed ? ST_WRBACK : ST_RESP;
                    end
                end
            end
            ST_WRBACK: begin
                if (mem_valid) begin
                    state_d = ST_RESP;
                end
            end
            ST_RESP: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Walk datapath and answer registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_top_q  <= 1'b1;
            base_ppn_q <= '0;
            vaddr_q    <= '0;
            acc_q      <= ACC_FETCH;
            mode_q     <= MODE_USER;
            sum_q      <= 1'b0;
            mxr_q      <= 1'b0;
            wb_pte_q   <= '0;
            fault_q    <= 1'b0;
            paddr_q    <= '0;
            r_q        <= 1'b0;
            w_q        <= 1'b0;
            x_q        <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        vaddr_q    <= req_vaddr;
                        acc_q      <= req_acc;
                        mode_q     <= req_mode;
                        sum_q      <= req_sum;
                        mxr_q      <= req_mxr;
                        base_ppn_q <= req_root_ppn;
                        lvl_top_q  <= 1'b1;
                        fault_q    <= 1'b0;
                        paddr_q    <= PA_W'(req_vaddr);
                        r_q        <= passthru;
                        w_q        <= passthru;
                        x_q        <= passthru;
                    end
                end
                ST_FETCH: begin
                    if (mem_valid) begin
                        if (!mem_err && is_ptr && lvl_top_q) begin
                            base_ppn_q <= pte_in.ppn;
                            lvl_top_q  <= 1'b0;
                        end else if (!mem_err && leaf_ok) begin
                            fault_q  <= 1'b0;
                            paddr_q  <= leaf_paddr;
                            r_q      <= pr;
                            w_q      <= pw;
                            x_q      <= px;
                            wb_pte_q <= pte_upd;
                        end else begin
                            fault_q <= 1'b1;
                            paddr_q <= '0;
                            r_q     <= 1'b0;
                            w_q     <= 1'b0;
                            x_q     <= 1'b0;
                        end
                    end
                end
                ST_WRBACK: begin
                    if (mem_valid && mem_err) begin
                        fault_q <= 1'b1;
                        paddr_q <= '0;
                        r_q     <= 1'b0;
                        w_q     <= 1'b0;
                        x_q     <= 1'b0;
                    end
                end
                ST_RESP: begin
                    lvl_top_q <= 1'b1;
                end
                default: begin
                    lvl_top_q <= 1'b1;
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        req_ready = (state_q == ST_IDLE);
        mem_req   = (state_q == ST_FETCH) || (state_q == ST_WRBACK);
        mem_we    = (state_q == ST_WRBACK);
        mem_addr  = pte_addr;
        mem_wdata = wb_pte_q;
        rsp_valid = (state_q == ST_RESP);
        rsp_fault = fault_q;
        rsp_paddr = paddr_q;
        rsp_r     = r_q;
        rsp_w     = w_q;
        rsp_x     = x_q;
    end

    // R12: a pending memory access keeps its address and direction until answered
    a_r12_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R12: the answer is a single-cycle pulse
    a_r12_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R12: ready only while nothing else is in flight
    a_r12_ready_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!mem_req && !rsp_valid));

    // R9: any write-back carries the accessed flag
    a_r9_wb_accessed: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> mem_wdata[6]);

    // R9: a store write-back carries the dirty flag
    a_r9_wb_dirty: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && (acc_q == ACC_STORE)) |-> mem_wdata[7]);

    // R11: a fault returns no rights
    a_r11_fault_noperm: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> !(rsp_r || rsp_w || rsp_x));

    // R1: a pass-through request never touches memory
    a_r1_passthru_nomem: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && req_valid && (req_xlat_off || (req_mode == MODE_MACH))) |=> (rsp_valid && !mem_req));
endmodule

// File: tb/tb_vmw_walker.sv
`timescale 1ns/1ps
module tb_vmw_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic [1:0]  req_acc = '0;
    logic [1:0]  req_mode = '0;
    logic        req_xlat_off = 1'b0;
    logic [21:0] req_root_ppn = '0;
    logic        req_sum = 1'b0;
    logic        req_mxr = 1'b0;
    logic        mem_req, mem_we;
    logic [33:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_valid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        mem_err = 1'b0;
    logic        rsp_valid, rsp_fault, rsp_r, rsp_w, rsp_x;
    logic [33:0] rsp_paddr;

    int nchk = 0;
    int nfail = 0;
    int reads = 0;
    int writes = 0;
    logic [33:0] first_rd;
    logic [33:0] err_rd_addr = 34'h3_FFFF_FFFF;
    logic [33:0] err_wr_addr = 34'h3_FFFF_FFFF;
    logic [31:0] pmem [logic [33:0]];
    bit done = 1'b0;

    always #2 clk = ~clk;

    vmw_walker dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .req_acc(req_acc), .req_mode(req_mode), .req_xlat_off(req_xlat_off),
        .req_root_ppn(req_root_ppn), .req_sum(req_sum), .req_mxr(req_mxr),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_valid(mem_valid), .mem_rdata(mem_rdata), .mem_err(mem_err),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr),
        .rsp_r(rsp_r), .rsp_w(rsp_w), .rsp_x(rsp_x)
    );

    function automatic logic [31:0] rd(input logic [33:0] a);
        return pmem.exists(a) ? pmem[a] : 32'h0;
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // memory responder
    initial begin
        forever begin
            @(negedge clk);
            if (mem_valid) begin
                mem_valid = 1'b0;
                mem_err   = 1'b0;
            end else if (mem_req && rst_n) begin
                repeat ($urandom % 3) @(negedge clk);
                if (mem_we) begin
                    writes++;
                    if (mem_addr == err_wr_addr) mem_err = 1'b1;
                    else pmem[mem_addr] = mem_wdata;
                end else begin
                    reads++;
                    if (reads == 1) first_rd = mem_addr;
                    if (mem_addr == err_rd_addr) mem_err = 1'b1;
                    mem_rdata = rd(mem_addr);
                end
                mem_valid = 1'b1;
            end
        end
    end

    // reference model built from the requirements
    task automatic ref_walk(input logic [31:0] va, input logic [1:0] acc,
                            input logic [1:0] mode, input logic off,
                            input logic [21:0] root, input logic sum, input logic mxr,
                            output logic f, output logic [33:0] pa,
                            output logic [2:0] rwx, output logic xl,
                            output logic [33:0] a1, output logic lv,
                            output logic [33:0] la, output logic [31:0] word,
                            output int nwr);
        logic [33:0] a;
        logic [31:0] p, np;
        logic top, own_bad, acc_bad;
        f = 1'b1; pa = '0; rwx = 3'b000; xl = 1'b0; lv = 1'b0; la = '0; word = '0; nwr = 0;
        a1 = {root, 12'h000} + {22'h0, va[31:22], 2'b00};
        if (mode == 2'd3 || off) begin
            f = 1'b0; pa = {2'b00, va}; rwx = 3'b111;
            return;
        end
        xl = 1'b1;
        a = a1; top = 1'b1;
        if (a == err_rd_addr) return;
        p = rd(a);
        if (!p[0]) return;
        if (p[3:1] == 3'b000) begin
            a = {p[31:10], 12'h000} + {22'h0, va[21:12], 2'b00};
            top = 1'b0;
            if (a == err_rd_addr) return;
            p = rd(a);
            if (!p[0]) return;
            if (p[3:1] == 3'b000) return;
        end
        if (p[2] && !p[1]) return;
        if (p[4]) own_bad = !((mode == 2'd0) || (mode == 2'd1 && sum && acc != 2'd0));
        else own_bad = (mode != 2'd1);
        if (own_bad) return;
        if (top && p[19:10] != 10'h0) return;
        case (acc)
            2'd1: acc_bad = !(p[1] || (p[3] && mxr));
            2'd2: acc_bad = !p[2];
            2'd0: acc_bad = !p[3];
            default: acc_bad = 1'b1;
        endcase
        if (acc_bad) return;
        lv = 1'b1; la = a; word = p;
        np = p | 32'h40 | ((acc == 2'd2) ? 32'h80 : 32'h0);
        if (np != p) begin
            nwr = 1;
            if (a == err_wr_addr) return;
            word = np;
        end
        f = 1'b0;
        pa = top ? {p[31:20], va[21:0]} : {p[31:10], va[11:0]};
        rwx = {p[1] || (p[3] && mxr), p[2] && (acc == 2'd2 || p[7]), p[3]};
    endtask

    task automatic run_case(input string tag, input logic [31:0] va, input logic [1:0] acc,
                            input logic [1:0] mode, input logic off, input logic [21:0] root,
                            input logic sum, input logic mxr);
        logic ef, exl, elv;
        logic [33:0] epa, ea1, ela;
        logic [2:0] erwx;
        logic [31:0] eword;
        int ewr, n;
        ref_walk(va, acc, mode, off, root, sum, mxr, ef, epa, erwx, exl, ea1, elv, ela, eword, ewr);
        reads = 0; writes = 0;
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; req_acc = acc; req_mode = mode;
        req_xlat_off = off; req_root_ppn = root; req_sum = sum; req_mxr = mxr;
        @(negedge clk);
        req_valid = 1'b0;
        n = 0;
        while (!rsp_valid && n < 200) begin
            @(negedge clk);
            n++;
        end
        if (!rsp_valid) begin
            chk("R12", "response timeout", 64'd0, 64'd1);
            return;
        end
        chk(tag, "fault", rsp_fault, ef);
        chk("R10", "paddr", rsp_paddr, epa);
        chk("R11", "rights", {rsp_r, rsp_w, rsp_x}, erwx);
        if (exl && reads > 0) chk("R2", "first entry address", first_rd, ea1);
        if (!exl) chk("R1", "memory reads", reads, 0);
        chk("R9", "write-backs", writes, ewr);
        if (elv) chk("R9", "entry word", rd(ela), eword);
        @(negedge clk);
        chk("R12", "rsp pulse", rsp_valid, 1'b0);
    endtask

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nfail++; nchk++;
            $display("FAIL R12 watchdog: actual hung expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
            $finish;
        end
    end

    localparam logic [21:0] ROOT = 22'h00040;
    localparam logic [21:0] L2PG = 22'h00100;

    function automatic logic [33:0] l1a(input logic [31:0] va);
        return {ROOT, 12'h0} + {22'h0, va[31:22], 2'b00};
    endfunction

    function automatic logic [33:0] l0a(input logic [31:0] va);
        return {L2PG, 12'h0} + {22'h0, va[21:12], 2'b00};
    endfunction

    function automatic logic [31:0] mk(input logic [21:0] ppn, input logic [7:0] fl);
        return {ppn, 2'b00, fl};
    endfunction

    initial begin
        logic [31:0] va;
        logic [1:0] acc, mode;
        logic [33:0] pick;
        void'($urandom(32'd20240607));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R12", "reset ready", req_ready, 1'b1);
        chk("R12", "reset rsp_valid", rsp_valid, 1'b0);
        chk("R12", "reset mem_req", mem_req, 1'b0);

        // R1 pass-through
        run_case("R1", 32'hDEADBEEF, 2'd1, 2'd3, 1'b0, ROOT, 1'b0, 1'b0);
        run_case("R1", 32'h8000_1234, 2'd0, 2'd1, 1'b1, ROOT, 1'b0, 1'b0);

        va = 32'h1234_5678;
        // R10 aligned superpage, supervisor load, flags V R W X
        pmem.delete();
        pmem[l1a(va)] = mk(22'h00C00, 8'h0F);
        run_case("R10", va, 2'd1, 2'd1, 1'b0, ROOT, 1'b0, 1'b0);
        // R7 misaligned superpage
        pmem[l1a(va)] = mk(22'h00C01, 8'h0F);
        run_case("R7", va, 2'd1, 2'd1, 1'b0, ROOT, 1'b0, 1'b0);
        // R5 write-only and write+execute
        pmem[l1a(va)] = mk(22'h00C00, 8'h05);
        run_case("R5", va, 2'd2, 2'd1, 1'b0, ROOT, 1'b0, 1'b0);
        pmem[l1a(va)] = mk(22'h00C00, 8'h0D);
        run_case("R5", va, 2'd0, 2'd1, 1'b0, ROOT, 1'b0, 1'b0);
        // R3 invalid entry and read error
        pmem[l1a(va)] = mk(22'h00C00, 8'h0E);
        run_case("R3", va, 2'd1, 2'd1, 1'b0, ROOT, 1'b0, 1'b0);
        pmem[l1a(va)] = mk(L2PG, 8'h01);
        pmem[l0a(va)] = mk(22'h2_0AB0, 8'h03);
        err_rd_addr = l0a(va);
        run_case("R3", va, 2'd1, 2'd1, 1'b0, ROOT, 1'b0, 1'b0);
        err_rd_addr = 34'h3_FFFF_FFFF;
        // R2 two-level walk success
        run_case("R2", va, 2'd1, 2'd1, 1'b0, ROOT, 1'b0, 1'b0);
        // R4 pointer at the second level
        pmem[l0a(va)] = mk(22'h2_0AB0, 8'h01);
        run_case("R4", va, 2'd1, 2'd1, 1'b0, ROOT, 1'b0, 1'b0);
        // R6 user page rules
        pmem[l0a(va)] = mk(22'h2_0AB0, 8'h1B);
        run_case("R6", va, 2'd1, 2'd1, 1'b0, ROOT, 1'b0, 1'b0);
        run_case("R6", va, 2'd1, 2'd1, 1'b0, ROOT, 1'b1, 1'b0);
        run_case("R6", va, 2'd0, 2'd1, 1'b0, ROOT, 1'b1, 1'b0);
        run_case("R6", va, 2'd0, 2'd0, 1'b0, ROOT, 1'b0, 1'b0);
        pmem[l0a(va)] = mk(22'h2_0AB0, 8'h0B);
        run_case("R6", va, 2'd1, 2'd0, 1'b0, ROOT, 1'b0, 1'b0);
        // R8 execute-only load with and without MXR; store on read-only
        pmem[l0a(va)] = mk(22'h2_0AB0, 8'h09);
        run_case("R8", va, 2'd1, 2'd1, 1'b0, ROOT, 1'b0, 1'b0);
        run_case("R8", va, 2'd1, 2'd1, 1'b0, ROOT, 1'b0, 1'b1);
        pmem[l0a(va)] = mk(22'h2_0AB0, 8'h03);
        run_case("R8", va, 2'd2, 2'd1, 1'b0, ROOT, 1'b0, 1'b0);
        // R9 flags already set: no write; failed write-back
        pmem[l0a(va)] = mk(22'h2_0AB0, 8'hC7);
        run_case("R9", va, 2'd2, 2'd1, 1'b0, ROOT, 1'b0, 1'b0);
        pmem[l0a(va)] = mk(22'h2_0AB0, 8'h07);
        err_wr_addr = l0a(va);
        run_case("R9", va, 2'd2, 2'd1, 1'b0, ROOT, 1'b0, 1'b0);
        err_wr_addr = 34'h3_FFFF_FFFF;
        // R11 load on writable page: write right only with D
        run_case("R11", va, 2'd1, 2'd1, 1'b0, ROOT, 1'b0, 1'b0);
        pmem[l0a(va)] = mk(22'h2_0AB0, 8'h87);
        run_case("R11", va, 2'd1, 2'd1, 1'b0, ROOT, 1'b0, 1'b0);

        // constrained random
        for (int t = 0; t < 400; t++) begin
            pmem.delete();
            va = $urandom;
            acc = 2'($urandom % 3);
            case ($urandom % 8)
                0: mode = 2'd3;
                1: mode = 2'd2;
                2, 3, 4: mode = 2'd1;
                default: mode = 2'd0;
            endcase
            if ($urandom % 2) begin
                pmem[l1a(va)] = mk(L2PG, 8'h01 | 8'($urandom % 2) << 5);
            end else begin
                pmem[l1a(va)] = mk(($urandom % 2) ? {12'($urandom), 10'h0} : 22'($urandom),
                                   8'($urandom) | (($urandom % 10) != 0 ? 8'h01 : 8'h00));
            end
            pmem[l0a(va)] = mk(22'($urandom),
                               8'($urandom) | (($urandom % 10) != 0 ? 8'h01 : 8'h00));
            pick = ($urandom % 2) ? l1a(va) : l0a(va);
            case ($urandom % 10)
                0: err_rd_addr = pick;
                1, 2: err_wr_addr = pick;
                default: ;
            endcase
            run_case("R4", va, acc, mode, ($urandom % 12) == 0, ROOT,
                     1'($urandom), 1'($urandom));
            err_rd_addr = 34'h3_FFFF_FFFF;
            err_wr_addr = 34'h3_FFFF_FFFF;
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
        $finish;
    end
endmodule